// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two stack pointers for a processor core, a main pointer and a process pointer, together with a two-bit control register. The control register picks which pointer the core sees as its active stack pointer in thread mode. In handler mode the main pointer is always the active one. The core reads and writes the active pointer through one port. Two further ports reach each pointer by name, whatever the current selection. Exception entry and exception return pulses move the selection: entry forces the main pointer, and a return to thread mode brings back the selection that was in force before.

Internally the selection is a small state machine with three states. ST_MAIN means thread mode uses the main pointer. ST_PROC means thread mode uses the process pointer. ST_HELD_PROC means an exception is active and the process selection is saved for the return. The transitions are:
- ST_MAIN to ST_PROC on a thread-mode control write with bit 1 set, and ST_PROC to ST_MAIN on a thread-mode control write with bit 1 clear.
- ST_PROC to ST_HELD_PROC on exception entry.
- ST_HELD_PROC to ST_PROC on an exception return to thread mode.
- All other events hold the state, including a nested entry or a return that stays in handler mode.

Control bit 0 is a sticky unprivileged flag. Software can set it, and only exception entry clears it. A parameter removes this flag.

Top module: `spbank_top`

## Requirements
- R1: When reset is sampled low at a clock edge, the main pointer loads `boot_sp_i` with bits [1:0] cleared. After reset the selection is the main pointer and the control register reads 0. The process pointer has no reset value.
- R2: While `handler_i` is 1, the active pointer is the main pointer whatever the control bit holds, and active-port writes go to the main pointer.
- R3: In thread mode, control bit 1 (spsel) chooses the process pointer when 1 and the main pointer when 0. This applies to both reads and writes on the active port.
- R4: Bits [1:0] of both pointers always read as 0, and the write data in those bits is dropped.
- R5: The control read value is `{spsel, unpriv}` (bit 1 spsel, bit 0 unpriv) in thread mode and 0 while `handler_i` is 1.
- R6: A control write while `handler_i` is 1 changes neither control bit.
- R7: With `UNPRIV_EN`=1, a thread-mode control write with bit 0 set sets the unpriv flag, and a write with bit 0 clear leaves it set. Only exception entry clears the flag. With `UNPRIV_EN`=0 the flag reads 0.
- R8: On exception entry the selection becomes the main pointer, and a thread-mode spsel of 1 is saved. Entry has priority over a control write in the same cycle.
- R9: An exception return with `ret_thread_i`=1 restores the saved spsel. A return with `ret_thread_i`=0 (nested) leaves the selection unchanged.
- R10: The named ports read and write their own pointer regardless of the selection. A named write overrides an active-port write to the same pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_sp_i | input | SP_W | Main pointer value loaded during reset |
| handler_i | input | 1 | 1 in handler mode, 0 in thread mode |
| exc_entry_i | input | 1 | Exception entry pulse |
| exc_return_i | input | 1 | Exception return pulse |
| ret_thread_i | input | 1 | With a return pulse: the return goes back to thread mode |
| act_wr_i | input | 1 | Write to the active pointer |
| act_wdata_i | input | SP_W | Write data for the active pointer |
| act_rdata_o | output | SP_W | Active pointer value |
| main_wr_i | input | 1 | Write to the main pointer by name |
| main_wdata_i | input | SP_W | Main pointer write data |
| main_rdata_o | output | SP_W | Main pointer value |
| proc_wr_i | input | 1 | Write to the process pointer by name |
| proc_wdata_i | input | SP_W | Process pointer write data |
| proc_rdata_o | output | SP_W | Process pointer value |
| ctrl_wr_i | input | 1 | Control register write |
| ctrl_wdata_i | input | 2 | Control write data: bit 1 spsel, bit 0 unpriv |
| ctrl_rdata_o | output | 2 | Control read value |

## Verification
The assertions assume that `handler_i` agrees with the entry and return pulses. It rises in the cycle after an entry from thread mode, and it falls only after a return with `ret_thread_i` set. They also assume that entry and return never pulse together and that a return comes only while an exception is active. The bench drives `handler_i` and `ret_thread_i` from its own nesting depth counter, so these conditions always hold. Entry is issued only below a small depth limit, return only at a nonzero depth, and the two are never issued in the same cycle.

// File: rtl/spbank_pkg.sv
`timescale 1ns/1ps
package spbank_pkg;
    typedef enum logic [1:0] {
        ST_MAIN      = 2'd0,
        ST_PROC      = 2'd1,
        ST_HELD_PROC = 2'd2
    } sel_state_e;

    localparam int NUM_BANKS      = 2;
    localparam int BANK_MAIN      = 0;
    localparam int BANK_PROC      = 1;
    localparam int CTRL_W         = 2;
    localparam int CTRL_SPSEL_BIT = 1;
    localparam int CTRL_UNPRIV_BIT = 0;
endpackage

// File: rtl/spbank_ptr_reg.sv
`timescale 1ns/1ps
module spbank_ptr_reg #(
    parameter int SP_W     = 32,
    parameter int ALIGN    = 2,
    parameter bit HAS_LOAD = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SP_W-1:0] load_val,
    input  logic            we,
    input  logic [SP_W-1:0] wdata,
    output logic [SP_W-1:0] q
);
    localparam logic [SP_W-1:0] KEEP = {{(SP_W-ALIGN){1'b1}}, {ALIGN{1'b0}}};

    logic [SP_W-1:0] q_r;

    generate
        if (HAS_LOAD) begin : g_load
            // pointer with a loaded reset value
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_r <= load_val & KEEP;
                else if (we)
                    q_r <= wdata & KEEP;
            end
        end else begin : g_noload
            // pointer with no defined reset value
            logic unused_inputs;
            assign unused_inputs = rst_n ^ (^load_val);
            always_ff @(posedge clk) begin
                if (we)
                    q_r <= wdata & KEEP;
            end
        end
    endgenerate

    assign q = q_r;

    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == ($past(wdata) & KEEP))); // R4
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(q)); // R10
endmodule

// File: rtl/spbank_sel_fsm.sv
`timescale 1ns/1ps
module spbank_sel_fsm
    import spbank_pkg::*;
#(
    parameter bit UNPRIV_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_i,
    input  logic              exc_entry_i,
    input  logic              exc_return_i,
    input  logic              ret_thread_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic              use_proc_o,
    output logic [CTRL_W-1:0] ctrl_rdata_o
);
    sel_state_e state_q, state_d;
    logic       unpriv_q;
    logic       sw_ctrl_wr;

    // software control write takes effect only in thread mode, no exception event
    assign sw_ctrl_wr = ctrl_wr_i && !handler_i && !exc_entry_i && !exc_return_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MAIN: begin
                if (sw_ctrl_wr && ctrl_wdata_i[CTRL_SPSEL_BIT])
                    state_d = ST_PROC;
            end
            ST_PROC: begin
                if (exc_entry_i)
                    state_d = ST_HELD_PROC;
                else if (sw_ctrl_wr && !ctrl_wdata_i[CTRL_SPSEL_BIT])
                    state_d = ST_MAIN;
            end
            ST_HELD_PROC: begin
                if (!exc_entry_i && exc_return_i && ret_thread_i)
                    state_d = ST_PROC;
            end
            default: state_d = ST_MAIN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_MAIN;
        else
            state_q <= state_d;
    end

    // unprivileged flag, present only when configured
    generate
        if (UNPRIV_EN) begin : g_unpriv
            always_ff @(posedge clk) begin
                if (!rst_n)
                    unpriv_q <= 1'b0;
                else if (exc_entry_i)
                    unpriv_q <= 1'b0;
                else if (sw_ctrl_wr && ctrl_wdata_i[CTRL_UNPRIV_BIT])
                    unpriv_q <= 1'b1;
            end

            AST_UNPRIV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (unpriv_q && !exc_entry_i) |=> unpriv_q); // R7
        end else begin : g_no_unpriv
            assign unpriv_q = 1'b0;
        end
    endgenerate

    // outputs
    always_comb begin
        use_proc_o   = 1'b0;
        ctrl_rdata_o = '0;
        if (!handler_i) begin
            use_proc_o                    = (state_q == ST_PROC);
            ctrl_rdata_o[CTRL_SPSEL_BIT]  = (state_q == ST_PROC);
            ctrl_rdata_o[CTRL_UNPRIV_BIT] = unpriv_q;
        end
    end

    AST_ENTRY_FORCES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry_i |=> (state_q != ST_PROC)); // R8
    AST_ENTRY_SAVES_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry_i && state_q == ST_PROC) |=> (state_q == ST_HELD_PROC)); // R8
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_i && ret_thread_i && !exc_entry_i && state_q == ST_HELD_PROC)
        |=> (state_q == ST_PROC)); // R9
    AST_NESTED_RETURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_i && !ret_thread_i && !exc_entry_i) |=> $stable(state_q)); // R9
    AST_HND_CTRL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_i && !exc_entry_i && !exc_return_i) |=> $stable(state_q)); // R6
endmodule

// File: rtl/spbank_top.sv
`timescale 1ns/1ps
module spbank_top
    import spbank_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter bit UNPRIV_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SP_W-1:0]   boot_sp_i,
    input  logic              handler_i,
    input  logic              exc_entry_i,
    input  logic              exc_return_i,
    input  logic              ret_thread_i,
    input  logic              act_wr_i,
    input  logic [SP_W-1:0]   act_wdata_i,
    output logic [SP_W-1:0]   act_rdata_o,
    input  logic              main_wr_i,
    input  logic [SP_W-1:0]   main_wdata_i,
    output logic [SP_W-1:0]   main_rdata_o,
    input  logic              proc_wr_i,
    input  logic [SP_W-1:0]   proc_wdata_i,
    output logic [SP_W-1:0]   proc_rdata_o,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rdata_o
);
    logic                 use_proc;
    logic [NUM_BANKS-1:0] named_we;
    logic [NUM_BANKS-1:0] bank_we;
    logic [SP_W-1:0]      named_wd [NUM_BANKS];
    logic [SP_W-1:0]      bank_wd  [NUM_BANKS];
    logic [SP_W-1:0]      bank_q   [NUM_BANKS];

    assign named_we[BANK_MAIN] = main_wr_i;
    assign named_we[BANK_PROC] = proc_wr_i;
    assign named_wd[BANK_MAIN] = main_wdata_i;
    assign named_wd[BANK_PROC] = proc_wdata_i;

    spbank_sel_fsm #(
        .UNPRIV_EN(UNPRIV_EN)
    ) sel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .handler_i   (handler_i),
        .exc_entry_i (exc_entry_i),
        .exc_return_i(exc_return_i),
        .ret_thread_i(ret_thread_i),
        .ctrl_wr_i   (ctrl_wr_i),
        .ctrl_wdata_i(ctrl_wdata_i),
        .use_proc_o  (use_proc),
        .ctrl_rdata_o(ctrl_rdata_o)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam bit IS_PROC = (b == BANK_PROC);
            logic act_hit;

            // the active port reaches this bank when the selection matches it
            assign act_hit    = act_wr_i && (use_proc == IS_PROC);
            assign bank_we[b] = named_we[b] | act_hit;
            assign bank_wd[b] = named_we[b] ? named_wd[b] : act_wdata_i;

            spbank_ptr_reg #(
                .SP_W    (SP_W),
                .ALIGN   (ALIGN_BITS),
                .HAS_LOAD(!IS_PROC)
            ) reg_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_val(boot_sp_i),
                .we      (bank_we[b]),
                .wdata   (bank_wd[b]),
                .q       (bank_q[b])
            );
        end
    endgenerate

    assign act_rdata_o  = use_proc ? bank_q[BANK_PROC] : bank_q[BANK_MAIN];
    assign main_rdata_o = bank_q[BANK_MAIN];
    assign proc_rdata_o = bank_q[BANK_PROC];

    AST_HND_USES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        handler_i |-> (act_rdata_o == main_rdata_o)); // R2
    AST_THREAD_PROC_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_i && ctrl_rdata_o[CTRL_SPSEL_BIT]) |-> (act_rdata_o == proc_rdata_o)); // R3
    AST_NAMED_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_wr_i && act_wr_i) |=> (proc_rdata_o == ($past(proc_wdata_i) & {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}}))); // R10
endmodule

// File: tb/spbank_top_tb_top.sv
`timescale 1ns/1ps
module spbank_top_tb_top;
    localparam logic [31:0] KEEP = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] boot_sp_i = 32'h2000_8003;
    logic        handler_i = 1'b0, exc_entry_i = 1'b0, exc_return_i = 1'b0, ret_thread_i = 1'b0;
    logic        act_wr_i = 1'b0, main_wr_i = 1'b0, proc_wr_i = 1'b0, ctrl_wr_i = 1'b0;
    logic [31:0] act_wdata_i = '0, main_wdata_i = '0, proc_wdata_i = '0;
    logic [1:0]  ctrl_wdata_i = '0;
    logic [31:0] act_rdata_o, main_rdata_o, proc_rdata_o;
    logic [1:0]  ctrl_rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_main, m_proc;
    bit m_spsel = 0, m_unpriv = 0, m_held = 0, proc_known = 0;
    int depth = 0;

    always #4 clk = ~clk;

    spbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .boot_sp_i(boot_sp_i), .handler_i(handler_i),
        .exc_entry_i(exc_entry_i), .exc_return_i(exc_return_i), .ret_thread_i(ret_thread_i),
        .act_wr_i(act_wr_i), .act_wdata_i(act_wdata_i), .act_rdata_o(act_rdata_o),
        .main_wr_i(main_wr_i), .main_wdata_i(main_wdata_i), .main_rdata_o(main_rdata_o),
        .proc_wr_i(proc_wr_i), .proc_wdata_i(proc_wdata_i), .proc_rdata_o(proc_rdata_o),
        .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(bit hnd);
        return hnd ? 32'd0 : {30'd0, m_spsel, m_unpriv};
    endfunction

    function automatic logic [31:0] exp_act(bit hnd);
        return (!hnd && m_spsel) ? m_proc : m_main;
    endfunction

    task automatic cyc(string tag, bit a_wr, logic [31:0] a_d, bit mw, logic [31:0] m_d,
                       bit pw, logic [31:0] p_d, bit c_wr, logic [1:0] c_d, bit ent, bit ret);
        bit hnd;
        bit use_p;
        hnd = (depth > 0);
        use_p = !hnd && m_spsel;
        handler_i = hnd; ret_thread_i = (depth == 1);
        exc_entry_i = ent; exc_return_i = ret;
        act_wr_i = a_wr; act_wdata_i = a_d;
        main_wr_i = mw; main_wdata_i = m_d;
        proc_wr_i = pw; proc_wdata_i = p_d;
        ctrl_wr_i = c_wr; ctrl_wdata_i = c_d;
        @(negedge clk);
        if (!use_p || proc_known) chk(tag, "active pointer", act_rdata_o, exp_act(hnd));
        chk(tag, "main pointer", main_rdata_o, m_main);
        if (proc_known) chk(tag, "process pointer", proc_rdata_o, m_proc);
        chk(tag, "control read", {30'd0, ctrl_rdata_o}, exp_ctrl(hnd));
        @(posedge clk);
        if (a_wr) begin
            if (use_p) begin m_proc = a_d & KEEP; proc_known = 1; end
            else m_main = a_d & KEEP;
        end
        if (mw) m_main = m_d & KEEP;
        if (pw) begin m_proc = p_d & KEEP; proc_known = 1; end
        if (ent) begin
            if (m_spsel) m_held = 1;
            m_spsel = 0; m_unpriv = 0; depth++;
        end else if (ret) begin
            if (depth == 1 && m_held) begin m_spsel = 1; m_held = 0; end
            depth--;
        end else if (c_wr && !hnd) begin
            m_spsel = c_d[1];
            if (c_d[0]) m_unpriv = 1;
        end
        #1;
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, '0, 0, '0, 0, '0, 0, 2'b00, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240613));
        // R1 reset load
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_main = boot_sp_i & KEEP;
        idle("R1");
        // R10 named write to the process pointer
        cyc("R10", 0, '0, 0, '0, 1, 32'h1000_0407, 0, 2'b00, 0, 0);
        // R4 low bits dropped on an active write
        cyc("R4", 1, 32'h2000_7FFF, 0, '0, 0, '0, 0, 2'b00, 0, 0);
        idle("R4");
        // R3 thread selection of the process pointer
        cyc("R3", 0, '0, 0, '0, 0, '0, 1, 2'b10, 0, 0);
        idle("R3");
        // R10 named write beats active write to the same pointer
        cyc("R10", 1, 32'hAAA0_0000, 0, '0, 1, 32'h5555_0002, 0, 2'b00, 0, 0);
        idle("R10");
        // R7 set then attempted clear of the unpriv flag
        cyc("R7", 0, '0, 0, '0, 0, '0, 1, 2'b11, 0, 0);
        cyc("R7", 0, '0, 0, '0, 0, '0, 1, 2'b10, 0, 0);
        idle("R7");
        // R8 entry together with a control write
        cyc("R8", 0, '0, 0, '0, 0, '0, 1, 2'b00, 1, 0);
        // R2 handler write goes to main
        cyc("R2", 1, 32'h3000_0001, 0, '0, 0, '0, 0, 2'b00, 0, 0);
        // R6 control write ignored in handler
        cyc("R6", 0, '0, 0, '0, 0, '0, 1, 2'b11, 0, 0);
        idle("R5");
        // R9 nesting
        cyc("R9", 0, '0, 0, '0, 0, '0, 0, 2'b00, 1, 0);
        cyc("R9", 0, '0, 0, '0, 0, '0, 0, 2'b00, 0, 1);
        idle("R9");
        cyc("R9", 0, '0, 0, '0, 0, '0, 0, 2'b00, 0, 1);
        idle("R9");
        cyc("R3", 0, '0, 0, '0, 0, '0, 1, 2'b00, 0, 0);
        idle("R3");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit ent, ret;
            ent = (depth < 3) && ($urandom_range(0, 99) < 8);
            ret = !ent && (depth > 0) && ($urandom_range(0, 99) < 10);
            cyc("R2/R3/R5 random",
                $urandom_range(0, 99) < 30, $urandom,
                $urandom_range(0, 99) < 10, $urandom,
                $urandom_range(0, 99) < 10, $urandom,
                $urandom_range(0, 99) < 25, 2'($urandom_range(0, 3)),
                ent, ret);
        end
        finish_run();
    end
endmodule